// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block produces the byte a parallel NOR flash puts on its data pins while an embedded program or erase operation is running. A command front end pulses `op_start` on the clock after the rising edge of the last write-enable pulse of a program or erase sequence. With that pulse it supplies the operation kind, the datum and the address being programmed, the sector selection and the per-sector protection flags. While the operation is in progress, each read cycle returns a status byte instead of array contents. Once the operation ends, reads return the array word that the surrounding model supplies on `array_q`.

Bit 7 is the polling bit. During a program it shows the inverse of the programmed datum's bit 7. During an erase it shows 0. Bit 6 flips on each new read strobe, so software that reads twice can tell whether work is still going on. If the operation's target is protected, no cell work takes place. The status is then held for a fixed window, about 2 µs for a program and about 100 µs for an erase, and reads then return to array data. That window is counted in clock cycles from a clock-frequency parameter. A normal operation ends when the cell engine pulses `op_done`.

Top module: `fsg_status_gen`

## Requirements
- R1: After reset the block is idle, `dq_o` equals `array_q`, and the internal toggle bit is 0.
- R2: `op_start` starts an operation only while the block is idle and only when `op_mode` is 1 (program), 2 (sector erase) or 3 (chip erase). The status byte appears from the next clock on. An `op_start` during an operation, or with mode 0, is ignored.
- R3: During a program, a read at the program address returns the inverse of bit 7 of the programmed datum on bit 7.
- R4: During an erase, a read at a valid address returns 0 on bit 7. The sector is the top SECT_BITS bits of the address. For a sector erase, a valid address lies in a selected sector. For a chip erase, a valid address lies in an unprotected sector.
- R5: While an operation runs, bit 6 reads 0 right after the start and flips once per read strobe assertion, where a strobe is `ce_n` and `oe_n` both low. The flip is visible one clock after the strobe is first sampled, and it happens at any address.
- R6: In a normal operation, `op_done` returns `dq_o` to `array_q` from the next clock on. After that, further read strobes leave `dq_o` equal to `array_q`.
- R7: A program whose address lies in a protected sector shows status for exactly CLK_MHZ*PROG_US cycles and then returns array data. `op_done` is ignored during that window.
- R8: An erase in which every targeted sector is protected shows status for exactly CLK_MHZ*ERASE_US cycles and then returns array data. The targeted sectors are the selected ones for a sector erase and all sectors for a chip erase.
- R9: An erase in which at least one targeted sector is unprotected is not timed. It stays in progress until `op_done`, even after the erase window length has passed.
- R10: During an operation, bits 5 to 0 of the status byte are 0 at a valid address. At an address that is not valid, bit 7 is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle pulse after the last write-enable edge of a command |
| op_mode | input | 2 | 1 program, 2 sector erase, 3 chip erase |
| prog_data | input | 8 | Datum being programmed |
| prog_addr | input | ADDR_W | Address being programmed |
| sect_sel | input | NSECT | Sectors selected for sector erase |
| sect_prot | input | NSECT | Per-sector protection flags |
| op_done | input | 1 | Completion pulse from the cell engine |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | ADDR_W | Read address |
| array_q | input | 8 | Array word at rd_addr |
| dq_o | output | 8 | Status byte or array word |

## Verification
The status byte appears in the first cycle after the clock edge that captures `op_start`. Every toggle flip appears one edge after a strobe is first sampled, and array data returns one edge after `op_done`. The bench drives all inputs on the falling edge and samples on the next falling edge, so each result is read exactly one register stage after its cause. For protected targets the bench counts falling edges from the start edge. It checks that status is still present on the last cycle of the window and that array data is present on the cycle right after it.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_SERASE = 2'd2,
    OP_CERASE = 2'd3
  } op_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WIN  = 2'd2
  } st_t;

  // length of a protected-target window in clock cycles (at least one)
  function automatic int unsigned win_cycles(int unsigned mhz, int unsigned us);
    int unsigned c;
    c = mhz * us;
    return (c == 0) ? 1 : c;
  endfunction

  // width of a counter able to hold n
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fsg_target.sv
module fsg_target
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int NSECT  = 8,
  parameter int SECT_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [1:0]        op_mode,
  input  logic [7:0]        prog_data,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [NSECT-1:0]  sect_sel,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              tgt_prot,
  output logic              tgt_erase,
  output logic              erase_q,
  output logic              addr_ok,
  output logic              poll_bit
);
  op_kind_t              mode_q;
  logic [7:0]            data_q;
  logic [ADDR_W-1:0]     paddr_q;
  logic [NSECT-1:0]      sel_q;
  logic [NSECT-1:0]      prot_q;
  logic [NSECT-1:0]      sel_in;
  logic [SECT_BITS-1:0]  psec_in;
  logic [SECT_BITS-1:0]  rsec;

  assign psec_in = prog_addr[ADDR_W-1 -: SECT_BITS];
  assign rsec    = rd_addr[ADDR_W-1 -: SECT_BITS];
  assign sel_in  = (op_kind_t'(op_mode) == OP_CERASE) ? {NSECT{1'b1}} : sect_sel;

  // protection decision uses the inputs present at the start pulse
  always_comb begin
    tgt_erase = (op_kind_t'(op_mode) == OP_SERASE) || (op_kind_t'(op_mode) == OP_CERASE);
    if (op_kind_t'(op_mode) == OP_PROG)
      tgt_prot = sect_prot[psec_in];
    else
      tgt_prot = ((sel_in & ~sect_prot) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= OP_NONE;
      data_q  <= '0;
      paddr_q <= '0;
      sel_q   <= '0;
      prot_q  <= '0;
    end else if (accept) begin
      mode_q  <= op_kind_t'(op_mode);
      data_q  <= prog_data;
      paddr_q <= prog_addr;
      sel_q   <= sel_in;
      prot_q  <= sect_prot;
    end
  end

  assign erase_q = (mode_q == OP_SERASE) || (mode_q == OP_CERASE);

  always_comb begin
    case (mode_q)
      OP_PROG:   addr_ok = (rd_addr == paddr_q);
      OP_SERASE: addr_ok = sel_q[rsec];
      OP_CERASE: addr_ok = ~prot_q[rsec];
      default:   addr_ok = 1'b0;
    endcase
    poll_bit = (mode_q == OP_PROG) ? ~data_q[7] : 1'b0;
  end
endmodule

// File: rtl/fsg_timer.sv
module fsg_timer
  import fsg_pkg::*;
#(
  parameter int CLK_MHZ  = 200,
  parameter int PROG_US  = 2,
  parameter int ERASE_US = 100,
  localparam int unsigned PROG_CYC  = win_cycles(CLK_MHZ, PROG_US),
  localparam int unsigned ERASE_CYC = win_cycles(CLK_MHZ, ERASE_US),
  localparam int unsigned MAX_CYC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int CNT_W = cnt_width(MAX_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             tgt_prot,
  input  logic             tgt_erase,
  input  logic             op_done,
  output logic             active,
  output logic             in_run,
  output logic             in_win,
  output logic [CNT_W-1:0] win_len
);
  st_t              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_sel;

  assign len_sel = tgt_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      win_len <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          if (tgt_prot) begin
            st_q    <= ST_WIN;
            cnt_q   <= len_sel - 1'b1;
            win_len <= len_sel;
          end else begin
            st_q <= ST_RUN;
          end
        end
        ST_RUN: if (op_done) st_q <= ST_IDLE;
        ST_WIN: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign active = (st_q != ST_IDLE);
  assign in_run = (st_q == ST_RUN);
  assign in_win = (st_q == ST_WIN);
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic accept,
  input  logic active,
  output logic rd_start,
  output logic tog
);
  logic strobe;
  logic strobe_q;

  assign strobe   = ~ce_n & ~oe_n;
  assign rd_start = strobe & ~strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      tog      <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (accept)                  tog <= 1'b0;
      else if (active && rd_start) tog <= ~tog;
    end
  end
endmodule

// File: rtl/fsg_status_gen.sv
module fsg_status_gen
  import fsg_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int NSECT    = 8,
  parameter int CLK_MHZ  = 200,
  parameter int PROG_US  = 2,
  parameter int ERASE_US = 100,
  localparam int SECT_BITS = (NSECT < 2) ? 1 : $clog2(NSECT),
  localparam int unsigned MAX_CYC = (win_cycles(CLK_MHZ, PROG_US) > win_cycles(CLK_MHZ, ERASE_US))
                                    ? win_cycles(CLK_MHZ, PROG_US) : win_cycles(CLK_MHZ, ERASE_US),
  localparam int CNT_W = cnt_width(MAX_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_mode,
  input  logic [7:0]        prog_data,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [NSECT-1:0]  sect_sel,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic              op_done,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_q,
  output logic [7:0]        dq_o
);
  logic             accept_w;
  logic             active_w;
  logic             run_w;
  logic             win_w;
  logic [CNT_W-1:0] win_len_w;
  logic             tgt_prot_w;
  logic             tgt_erase_w;
  logic             erase_w;
  logic             addr_ok_w;
  logic             poll_w;
  logic             rd_start_w;
  logic             tog_w;

  assign accept_w = op_start && !active_w && (op_kind_t'(op_mode) != OP_NONE);

  fsg_target #(.ADDR_W(ADDR_W), .NSECT(NSECT), .SECT_BITS(SECT_BITS)) target_i (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .op_mode(op_mode),
    .prog_data(prog_data), .prog_addr(prog_addr), .sect_sel(sect_sel),
    .sect_prot(sect_prot), .rd_addr(rd_addr), .tgt_prot(tgt_prot_w),
    .tgt_erase(tgt_erase_w), .erase_q(erase_w), .addr_ok(addr_ok_w), .poll_bit(poll_w)
  );

  fsg_timer #(.CLK_MHZ(CLK_MHZ), .PROG_US(PROG_US), .ERASE_US(ERASE_US)) timer_i (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .tgt_prot(tgt_prot_w),
    .tgt_erase(tgt_erase_w), .op_done(op_done), .active(active_w),
    .in_run(run_w), .in_win(win_w), .win_len(win_len_w)
  );

  fsg_toggle toggle_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .accept(accept_w),
    .active(active_w), .rd_start(rd_start_w), .tog(tog_w)
  );

  always_comb begin
    if (!active_w)       dq_o = array_q;
    else if (addr_ok_w)  dq_o = {poll_w, tog_w, 6'b0};
    else                 dq_o = {1'b1, tog_w, 6'b0};
  end
endmodule

// File: rtl/fsg_status_chk.sv
module fsg_status_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_done,
  input logic [7:0]       dq_o,
  input logic [7:0]       array_q,
  input logic             accept_w,
  input logic             active_w,
  input logic             run_w,
  input logic             win_w,
  input logic [CNT_W-1:0] win_len_w,
  input logic             erase_w,
  input logic             addr_ok_w,
  input logic             rd_start_w,
  input logic             tog_w
);
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_q <= '0;
    else if (win_w)  seen_q <= seen_q + 1'b1;
    else             seen_q <= '0;
  end

  // R2
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (active_w && !tog_w));

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && rd_start_w && !accept_w) |=> (tog_w != $past(tog_w)));

  // R6
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(active_w && rd_start_w) && !accept_w) |=> $stable(tog_w));

  // R6
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && op_done) |=> (!active_w && dq_o == array_q));

  // R7
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_w |-> (seen_q < win_len_w));

  // R4
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && erase_w && addr_ok_w) |-> (dq_o[7] == 1'b0 && dq_o[5:0] == 6'b0));
endmodule

bind fsg_status_gen fsg_status_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_done(op_done), .dq_o(dq_o), .array_q(array_q),
  .accept_w(accept_w), .active_w(active_w), .run_w(run_w), .win_w(win_w),
  .win_len_w(win_len_w), .erase_w(erase_w), .addr_ok_w(addr_ok_w),
  .rd_start_w(rd_start_w), .tog_w(tog_w)
);

// File: tb/fsg_status_gen_tb.sv
`timescale 1ns/1ps
module fsg_status_gen_tb_top;
  localparam int AW  = 17;
  localparam int NS  = 8;
  localparam int SB  = 3;
  localparam int MHZ = 4;
  localparam int PW  = MHZ * 2;
  localparam int EW  = MHZ * 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_start = 1'b0;
  logic [1:0]    op_mode = 2'd0;
  logic [7:0]    prog_data = 8'h00;
  logic [AW-1:0] prog_addr = '0;
  logic [NS-1:0] sect_sel = '0;
  logic [NS-1:0] sect_prot = '0;
  logic          op_done = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    array_q = 8'h5A;
  logic [7:0]    dq_o;

  int n_chk = 0;
  int n_fail = 0;
  int j = 0;
  int nreads = 0;
  logic [1:0]    c_mode;
  logic [7:0]    c_data;
  logic [AW-1:0] c_paddr;
  logic [NS-1:0] c_sel;
  logic [NS-1:0] c_prot;

  always #2.5 clk = ~clk;

  fsg_status_gen #(.ADDR_W(AW), .NSECT(NS), .CLK_MHZ(MHZ), .PROG_US(2), .ERASE_US(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_mode(op_mode),
    .prog_data(prog_data), .prog_addr(prog_addr), .sect_sel(sect_sel),
    .sect_prot(sect_prot), .op_done(op_done), .ce_n(ce_n), .oe_n(oe_n),
    .rd_addr(rd_addr), .array_q(array_q), .dq_o(dq_o)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    j++;
  endtask

  function automatic logic [SB-1:0] sec_of(input logic [AW-1:0] a);
    return a[AW-1 -: SB];
  endfunction

  function automatic bit is_prot_target(input logic [1:0] m, input logic [AW-1:0] pa,
                                        input logic [NS-1:0] s, input logic [NS-1:0] p);
    if (m == 2'd1) return p[sec_of(pa)];
    if (m == 2'd2) return (s & ~p) == '0;
    return &p;
  endfunction

  function automatic bit addr_valid(input logic [AW-1:0] a);
    if (c_mode == 2'd1) return a == c_paddr;
    if (c_mode == 2'd2) return c_sel[sec_of(a)];
    return !c_prot[sec_of(a)];
  endfunction

  function automatic bit exp_poll();
    return (c_mode == 2'd1) ? ~c_data[7] : 1'b0;
  endfunction

  task automatic start_op(input logic [1:0] m, input logic [7:0] d, input logic [AW-1:0] pa,
                          input logic [NS-1:0] s, input logic [NS-1:0] p);
    c_mode = m; c_data = d; c_paddr = pa; c_sel = s; c_prot = p;
    op_mode = m; prog_data = d; prog_addr = pa; sect_sel = s; sect_prot = p;
    op_start = 1'b1;
    step();
    op_start = 1'b0;
    op_mode = 2'd0; prog_data = ~d;
    j = 0;
    nreads = 0;
    // R2: status from the first cycle after the start edge (bits 5:0 are 0, array has them set)
    check(dq_o[5:0] == 6'b0 && dq_o[6] == 1'b0, "R2", dq_o, {dq_o[7], 7'b0});
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    logic [7:0] e;
    rd_addr = a;
    ce_n = 1'b0;
    oe_n = 1'b0;
    step();
    nreads++;
    e = {exp_poll(), nreads[0], 6'b0};
    // R5
    check(dq_o[6] == nreads[0], "R5", dq_o, e);
    if (addr_valid(a)) begin
      if (c_mode == 2'd1) check(dq_o[7] == e[7], "R3", dq_o, e);
      else                check(dq_o[7] == e[7], "R4", dq_o, e);
      // R10
      check(dq_o[5:0] == 6'b0, "R10", dq_o, e);
    end
    ce_n = 1'b1;
    oe_n = 1'b1;
    step();
  endtask

  function automatic logic [AW-1:0] pick_addr();
    logic [AW-1:0] a;
    a = AW'($urandom);
    if (($urandom % 2) == 0 && c_mode == 2'd1) a = c_paddr;
    return a;
  endfunction

  task automatic run_op(input logic [1:0] m, input logic [7:0] d, input logic [AW-1:0] pa,
                        input logic [NS-1:0] s, input logic [NS-1:0] p, input bit long_wait);
    int win;
    int nr;
    array_q = 8'h3F | (8'($urandom) & 8'hC0);
    start_op(m, d, pa, s, p);
    if (is_prot_target(m, pa, s, p)) begin
      win = (m == 2'd1) ? PW : EW;
      op_done = 1'b1;
      step();
      op_done = 1'b0;
      // R7: op_done ignored inside the window
      check(dq_o[5:0] == 6'b0, "R7", dq_o, {dq_o[7:6], 6'b0});
      nr = (m == 2'd1) ? 1 : 1 + int'($urandom % 3);
      for (int k = 0; k < nr; k++) do_read(pick_addr());
      while (j < win - 1) step();
      if (m == 2'd1) begin
        check(dq_o[6:0] == {nreads[0], 6'b0}, "R7", dq_o, {dq_o[7], nreads[0], 6'b0});
        step();
        check(dq_o == array_q, "R7", dq_o, array_q);
      end else begin
        check(dq_o[6:0] == {nreads[0], 6'b0}, "R8", dq_o, {dq_o[7], nreads[0], 6'b0});
        step();
        check(dq_o == array_q, "R8", dq_o, array_q);
      end
    end else begin
      nr = 1 + int'($urandom % 4);
      for (int k = 0; k < nr; k++) do_read(pick_addr());
      if (m == 2'd1) begin
        // R2: a second start while busy is ignored
        op_mode = 2'd1; prog_data = ~d; prog_addr = pa; op_start = 1'b1;
        step();
        op_start = 1'b0; op_mode = 2'd0;
        do_read(pa);
      end
      if (long_wait) begin
        while (j < EW + 4) step();
        // R9
        check(dq_o[5:0] == 6'b0 && dq_o[6] == nreads[0], "R9", dq_o, {dq_o[7], nreads[0], 6'b0});
      end
      op_done = 1'b1;
      step();
      op_done = 1'b0;
      check(dq_o == array_q, "R6", dq_o, array_q);
      rd_addr = pa; ce_n = 1'b0; oe_n = 1'b0;
      step();
      check(dq_o == array_q, "R6", dq_o, array_q);
      ce_n = 1'b1; oe_n = 1'b1;
      step();
      check(dq_o == array_q, "R6", dq_o, array_q);
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1F2E3D4C);
    repeat (3) @(negedge clk);
    // R1
    check(dq_o == array_q, "R1", dq_o, array_q);
    rst_n = 1'b1;
    @(negedge clk);
    check(dq_o == array_q, "R1", dq_o, array_q);
    // R2: mode 0 start does nothing
    op_mode = 2'd0; op_start = 1'b1;
    step();
    op_start = 1'b0;
    check(dq_o == array_q, "R2", dq_o, array_q);

    // directed corners
    run_op(2'd1, 8'h80, 17'h0_1234, 8'h00, 8'h00, 1'b0);
    run_op(2'd1, 8'h7F, 17'h1_5678, 8'h00, 8'h00, 1'b0);
    run_op(2'd1, 8'hAA, 17'h1_F000, 8'h00, 8'h80, 1'b0);
    run_op(2'd2, 8'h00, 17'h0_0000, 8'h0C, 8'h0C, 1'b0);
    run_op(2'd3, 8'h00, 17'h0_0000, 8'h00, 8'hFF, 1'b0);
    run_op(2'd2, 8'h00, 17'h0_0000, 8'h0C, 8'h04, 1'b1);
    run_op(2'd3, 8'h00, 17'h0_0000, 8'h00, 8'hF7, 1'b0);

    // constrained random operations
    for (int n = 0; n < 40; n++) begin
      logic [1:0]    m;
      logic [NS-1:0] s;
      logic [NS-1:0] p;
      m = 2'(1 + ($urandom % 3));
      s = NS'($urandom);
      p = NS'($urandom) & NS'($urandom);
      if ((m != 2'd1) && (($urandom % 5) != 0)) p = p & ~s;
      run_op(m, 8'($urandom), AW'($urandom), s, p, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule